// File: doc/BRIEF.md
# Telemetry Sample Frame Decoder

This block turns an already-demodulated serial bit stream into complete telemetry samples. One bit arrives on each cycle in which the bit-valid strobe is high. Cycles without the strobe are gaps: the bit line is ignored and no state moves.

Each frame opens with a run of ones used for synchronisation, followed by a single zero start bit. After the start bit come a 4-bit device identifier, a 16-bit sample, and the bitwise complement of the identifier. The decoder hunts for the sync run, collects the fields, and checks the trailing complement against the identifier. A frame that passes is reported with a one-cycle valid pulse and its identifier and sample. A frame that fails the check is dropped with a one-cycle error pulse.

An identifier filter input can restrict reception to one device. The all-ones filter value accepts every device. Bit-clock recovery, frequency demodulation and storage of the samples are done elsewhere.

Top module: `telemetry_frame_decoder`

## Requirements
- R1: While `rst_n` is low and after its release, `frame_valid` and `frame_error` are 0 and `frame_id` and `frame_sample` read 0 until the first accepted frame.
- R2: A 0 is taken as the start bit only after at least MIN_SYNC (default 8) consecutive strobed ones. A 0 after fewer ones restarts the hunt, so that frame yields no pulse at all.
- R3: The 24 bits after the start bit are decoded in this order:
  - the identifier, MSB first;
  - the 16-bit sample, with the first bit as bit 15;
  - the complement of the identifier, MSB first.
- R4: A frame whose trailing 4 bits equal the bitwise inverse of its identifier, and which passes the filter, gives exactly one cycle of `frame_valid` with `frame_id` and `frame_sample` set to the received values, and no `frame_error`.
- R5: A frame whose trailing 4 bits are not the exact inverse of its identifier gives exactly one cycle of `frame_error`, no `frame_valid`, and leaves `frame_id` and `frame_sample` unchanged.
- R6: With `id_filter` = 15 every identifier is accepted. With any other value, a well-formed frame carrying a different identifier gives neither pulse and leaves the outputs unchanged. A complement failure still raises `frame_error` whatever the filter.
- R7: `bit_in` is ignored in cycles where `bit_valid` is low. Idle cycles between bits, whatever `bit_in` holds, do not change the decoded result.
- R8: After the last bit of a frame the decoder returns to hunting with its ones count cleared. A following frame needs a fresh sync run of at least MIN_SYNC ones.
- R9: Sync runs longer than MIN_SYNC ones are accepted, and the frame after them is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_valid | input | 1 | Strobe marking a cycle that carries one stream bit |
| bit_in | input | 1 | Demodulated stream bit, sampled when `bit_valid` is 1 |
| id_filter | input | 4 | Identifier to accept; 15 accepts every identifier |
| frame_valid | output | 1 | One-cycle pulse for an accepted frame |
| frame_id | output | 4 | Identifier of the last accepted frame |
| frame_sample | output | 16 | Sample of the last accepted frame |
| frame_error | output | 1 | One-cycle pulse for a frame that fails the complement check |

## Verification
The hardest cases to reach are the ones where the decoder must stay silent: a start bit after too short a sync run, a frame straight after another without fresh sync, and a filtered-out identifier. In each case nothing at the ports moves. The stimulus builds these streams so that the fields that follow contain no accidental run of eight ones and zero, which would otherwise open a frame by chance. It then follows each silent stream with a proper frame, showing that the hunt recovered and that the held outputs were not disturbed. Gaps carrying toggling garbage on `bit_in` are inserted between strobed bits to show that only strobed bits count.

// File: rtl/tfd_pkg.sv
// Shared types for the telemetry frame decoder.
// Assumes: nothing beyond IEEE 1800-2017.
package tfd_pkg;

    // Decoder phase: hunting for sync, or collecting frame fields
    typedef enum logic {
        PH_HUNT   = 1'b0,
        PH_FIELDS = 1'b1
    } tfd_phase_e;

endpackage

// File: rtl/tfd_sync_hunter.sv
// Hunts for a run of at least MIN_SYNC ones followed by a zero start bit,
// then holds the field phase until the field collector reports its last bit.
// Assumes: bit_in is meaningful only when bit_valid is high.
module tfd_sync_hunter
    import tfd_pkg::*;
#(
    parameter int MIN_SYNC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_in,
    input  logic last_bit,
    output logic in_frame
);

    localparam int OW = $clog2(MIN_SYNC + 1);
    localparam logic [OW-1:0] ONES_TOP = OW'(MIN_SYNC);

    tfd_phase_e     phase;
    logic [OW-1:0]  ones_cnt;

    // Phase and saturating ones counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_HUNT;
            ones_cnt <= '0;
        end else begin
            case (phase)
                PH_HUNT: begin
                    if (bit_valid) begin
                        if (bit_in) begin
                            if (ones_cnt != ONES_TOP) ones_cnt <= ones_cnt + 1'b1;
                        end else begin
                            if (ones_cnt == ONES_TOP) phase <= PH_FIELDS;
                            ones_cnt <= '0;
                        end
                    end
                end
                default: begin
                    if (last_bit) phase <= PH_HUNT;
                end
            endcase
        end
    end

    assign in_frame = (phase == PH_FIELDS);

    // R2
    sync_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_frame) |-> ($past(ones_cnt) == ONES_TOP && !$past(bit_in)));

    // R8
    hunt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_frame) |-> (ones_cnt == '0));

endmodule

// File: rtl/tfd_field_shifter.sv
// Shifts in the identifier, sample and inverted identifier after the start bit,
// and raises a one-cycle full pulse once all field bits are held.
// Assumes: in_frame rises the cycle after the start bit was taken.
module tfd_field_shifter #(
    parameter int ID_W   = 4,
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_frame,
    input  logic                  bit_valid,
    input  logic                  bit_in,
    output logic                  last_bit,
    output logic                  full,
    output logic [2*ID_W+DATA_W-1:0] fields
);

    localparam int TOTAL = 2 * ID_W + DATA_W;
    localparam int CW    = $clog2(TOTAL);
    localparam logic [CW-1:0] LAST_IDX = CW'(TOTAL - 1);

    logic [CW-1:0] bit_cnt;

    assign last_bit = in_frame && bit_valid && (bit_cnt == LAST_IDX);

    // Field shift register, bit counter and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            fields  <= '0;
            full    <= 1'b0;
        end else begin
            full <= 1'b0;
            if (!in_frame) begin
                bit_cnt <= '0;
            end else if (bit_valid) begin
                fields <= {fields[TOTAL-2:0], bit_in};
                if (bit_cnt == LAST_IDX) begin
                    bit_cnt <= '0;
                    full    <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // R7
    gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> $stable(fields));

    // R8
    full_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> !full);

endmodule

// File: rtl/tfd_frame_checker.sv
// Splits the collected fields, checks the inverted identifier, applies the
// optional identifier filter and registers the result outputs.
// Assumes: full is a one-cycle pulse with fields stable in that cycle.
module tfd_frame_checker #(
    parameter int ID_W      = 4,
    parameter int DATA_W    = 16,
    parameter bit FILTER_EN = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      full,
    input  logic [2*ID_W+DATA_W-1:0]  fields,
    input  logic [ID_W-1:0]           id_filter,
    output logic                      frame_valid,
    output logic                      frame_error,
    output logic [ID_W-1:0]           frame_id,
    output logic [DATA_W-1:0]         frame_sample
);

    localparam int TOTAL = 2 * ID_W + DATA_W;
    localparam logic [ID_W-1:0] ACCEPT_ALL = '1;

    logic [ID_W-1:0]   rx_id;
    logic [DATA_W-1:0] rx_data;
    logic [ID_W-1:0]   rx_inv;
    logic              id_ok;
    logic              check_ok;

    assign rx_id    = fields[TOTAL-1 -: ID_W];
    assign rx_data  = fields[ID_W+DATA_W-1 -: DATA_W];
    assign rx_inv   = fields[ID_W-1:0];
    assign check_ok = (rx_inv == ~rx_id);

    generate
        if (FILTER_EN) begin : g_filter
            assign id_ok = (id_filter == ACCEPT_ALL) || (id_filter == rx_id);
        end else begin : g_nofilter
            logic unused_filter;
            assign unused_filter = ^id_filter;
            assign id_ok = 1'b1;
        end
    endgenerate

    // Result pulses and held identifier/sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_valid  <= 1'b0;
            frame_error  <= 1'b0;
            frame_id     <= '0;
            frame_sample <= '0;
        end else begin
            frame_valid <= 1'b0;
            frame_error <= 1'b0;
            if (full) begin
                if (!check_ok) begin
                    frame_error <= 1'b1;
                end else if (id_ok) begin
                    frame_valid  <= 1'b1;
                    frame_id     <= rx_id;
                    frame_sample <= rx_data;
                end
            end
        end
    end

    // R4 R5
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_valid && frame_error));

    // R4
    valid_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    // R5
    error_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_error |=> !frame_error);

    // R6
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(frame_id) || !$stable(frame_sample)) |-> frame_valid);

    // R4
    valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> $past(full));

endmodule

// File: rtl/telemetry_frame_decoder.sv
// Telemetry frame decoder top: sync hunt, field collection and check.
// Assumes: one stream bit per bit_valid cycle, clock already recovered.
module telemetry_frame_decoder #(
    parameter int ID_W      = 4,
    parameter int DATA_W    = 16,
    parameter int MIN_SYNC  = 8,
    parameter bit FILTER_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic [ID_W-1:0]   id_filter,
    output logic              frame_valid,
    output logic [ID_W-1:0]   frame_id,
    output logic [DATA_W-1:0] frame_sample,
    output logic              frame_error
);

    localparam int TOTAL = 2 * ID_W + DATA_W;

    logic             in_frame;
    logic             last_bit;
    logic             full;
    logic [TOTAL-1:0] fields;

    tfd_sync_hunter #(.MIN_SYNC(MIN_SYNC)) u_hunt (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .last_bit  (last_bit),
        .in_frame  (in_frame)
    );

    tfd_field_shifter #(.ID_W(ID_W), .DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_frame  (in_frame),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .last_bit  (last_bit),
        .full      (full),
        .fields    (fields)
    );

    tfd_frame_checker #(.ID_W(ID_W), .DATA_W(DATA_W), .FILTER_EN(FILTER_EN)) u_chk (
        .clk          (clk),
        .rst_n        (rst_n),
        .full         (full),
        .fields       (fields),
        .id_filter    (id_filter),
        .frame_valid  (frame_valid),
        .frame_error  (frame_error),
        .frame_id     (frame_id),
        .frame_sample (frame_sample)
    );

endmodule

// File: tb/test_telemetry_frame_decoder.sv
module test_telemetry_frame_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_valid = 1'b0;
    logic        bit_in = 1'b0;
    logic [3:0]  id_filter = 4'hF;
    logic        frame_valid;
    logic [3:0]  frame_id;
    logic [15:0] frame_sample;
    logic        frame_error;

    int n_checks = 0;
    int n_fail   = 0;
    int n_v = 0;
    int n_e = 0;
    logic [3:0]  exp_id = 4'h0;
    logic [15:0] exp_data = 16'h0;

    always #10 clk = ~clk;

    telemetry_frame_decoder i_telemetry_frame_decoder (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .id_filter(id_filter), .frame_valid(frame_valid), .frame_id(frame_id),
        .frame_sample(frame_sample), .frame_error(frame_error)
    );

    // vector: sync len, id, data, trailing inv, filter, expect valid, expect error
    localparam logic [35:0] VECS [9] = '{
        {6'd11, 4'h1, 16'hA5C3, 4'hE, 4'hF, 1'b1, 1'b0},
        {6'd8,  4'h9, 16'h1234, 4'h6, 4'hF, 1'b1, 1'b0},
        {6'd20, 4'h0, 16'hFFFF, 4'hF, 4'hF, 1'b1, 1'b0},
        {6'd11, 4'h7, 16'h0001, 4'h7, 4'hF, 1'b0, 1'b1},
        {6'd11, 4'h3, 16'h8000, 4'hC, 4'h3, 1'b1, 1'b0},
        {6'd11, 4'h4, 16'h5555, 4'hB, 4'h3, 1'b0, 1'b0},
        {6'd11, 4'h4, 16'h1111, 4'h4, 4'h3, 1'b0, 1'b1},
        {6'd12, 4'hF, 16'h0F0F, 4'h0, 4'h2, 1'b0, 1'b0},
        {6'd11, 4'hF, 16'h00FF, 4'h0, 4'hF, 1'b1, 1'b0}
    };

    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_valid) n_v = n_v + 1;
            if (frame_error) n_e = n_e + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input int gap);
        @(negedge clk);
        bit_valid = 1'b1;
        bit_in = b;
        @(negedge clk);
        bit_valid = 1'b0;
        bit_in = ~b;
        for (int g = 0; g < gap; g++) begin
            bit_in = ~bit_in;
            @(negedge clk);
        end
    endtask

    task automatic send_fields(input logic [3:0] id, input logic [15:0] d, input logic [3:0] inv, input int gap);
        for (int i = 3; i >= 0; i--)  send_bit(id[i], gap);
        for (int i = 15; i >= 0; i--) send_bit(d[i], gap);
        for (int i = 3; i >= 0; i--)  send_bit(inv[i], gap);
    endtask

    task automatic send_frame(input int sync, input logic [3:0] id, input logic [15:0] d, input logic [3:0] inv, input int gap);
        for (int i = 0; i < sync; i++) send_bit(1'b1, gap);
        send_bit(1'b0, gap);
        send_fields(id, d, inv, gap);
    endtask

    task automatic settle_and_check(input bit ev, input bit ee, input string req);
        repeat (4) @(negedge clk);
        if (ev) begin
            exp_id = frame_id_exp_hold;
            exp_data = frame_data_exp_hold;
        end
        chk(n_v == int'(ev), {req, " valid pulses"}, n_v, ev);
        chk(n_e == int'(ee), {req, " error pulses"}, n_e, ee);
        chk(frame_id == exp_id, {req, " frame_id"}, frame_id, exp_id);
        chk(frame_sample == exp_data, {req, " frame_sample"}, frame_sample, exp_data);
        n_v = 0;
        n_e = 0;
    endtask

    logic [3:0]  frame_id_exp_hold;
    logic [15:0] frame_data_exp_hold;

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (5) @(negedge clk);
        chk(!frame_valid && !frame_error, "R1 pulses in reset", {frame_valid, frame_error}, 0);
        chk(frame_id == 0 && frame_sample == 0, "R1 outputs in reset", {frame_id, frame_sample}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!frame_valid && !frame_error && frame_id == 0 && frame_sample == 0,
            "R1 after release", {frame_valid, frame_error, frame_id, frame_sample}, 0);

        // table walk: R3 R4 R5 R6 R9
        foreach (VECS[k]) begin
            logic [35:0] v;
            v = VECS[k];
            id_filter = v[5:2];
            frame_id_exp_hold = v[29:26];
            frame_data_exp_hold = v[25:10];
            send_frame(int'(v[35:30]), v[29:26], v[25:10], v[9:6], 0);
            settle_and_check(v[1], v[0], "R3 R4 R5 R6 R9 table");
        end

        id_filter = 4'hF;

        // R2: seven ones then zero must not open a frame
        for (int i = 0; i < 7; i++) send_bit(1'b1, 0);
        send_bit(1'b0, 0);
        send_fields(4'h2, 16'h0000, 4'hD, 0);
        repeat (3) send_bit(1'b0, 0);
        settle_and_check(1'b0, 1'b0, "R2 short sync");

        // R2: hunt recovers on next proper frame
        frame_id_exp_hold = 4'h6;
        frame_data_exp_hold = 16'hBEEF;
        send_frame(8, 4'h6, 16'hBEEF, 4'h9, 0);
        settle_and_check(1'b1, 1'b0, "R2 recovery");

        // R8: frame with no fresh sync after a good frame
        frame_id_exp_hold = 4'hA;
        frame_data_exp_hold = 16'h0000;
        send_frame(9, 4'hA, 16'h0000, 4'h5, 0);
        send_bit(1'b0, 0);
        send_fields(4'h2, 16'h0000, 4'hD, 0);
        repeat (4) @(negedge clk);
        chk(n_v == 1, "R8 only first frame valid", n_v, 1);
        chk(n_e == 0, "R8 no error", n_e, 0);
        chk(frame_id == 4'hA && frame_sample == 16'h0000, "R8 held outputs", {frame_id, frame_sample}, {4'hA, 16'h0000});
        exp_id = 4'hA;
        exp_data = 16'h0000;
        n_v = 0;
        n_e = 0;

        // R7: gaps with toggling garbage between strobed bits
        frame_id_exp_hold = 4'h5;
        frame_data_exp_hold = 16'hC3A5;
        send_frame(10, 4'h5, 16'hC3A5, 4'hA, 3);
        settle_and_check(1'b1, 1'b0, "R7 gapped stream");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule